// File: doc/BRIEF.md
# Shared Mailbox Interrupt Controller

This block holds a bank of single-word mailboxes through which one processor passes a value to another. Each word carries its own FULL flag in the top bit. A producer fills a slot by writing a payload with that bit set. The consumer drains the slot by writing all zeros, which clears the payload along with the flag. The block reports every slot's EMPTY and FULL condition as a level, in two separate byte lanes of one status word.

The conditions are combined onto several level-sensitive shared interrupt lines. Each line has its own mask over the status layout, and each slot has its own FULL and EMPTY enables. A line is raised when a status bit is set, the line's mask bit for it is set, and the slot's enable for that condition is set. A read-only dimensioning word lets software find the slot count, the other resource counts and the number of shared lines. Access uses a plain single-cycle register port: address, write data, write strobe, and combinational read data.

Address map (byte addresses): line n mask at 0x100 + 4·n; status at 0x304; dimensioning at 0x380. Slot i has a window at 0x400 + 0x10·i, with the data word at +0x0, the FULL enable at +0x4 and the EMPTY enable at +0x8.

Top module: `smb_ctrl`

## Requirements
- R1: Writing a slot's data word stores all 32 bits, and reading it returns them unchanged. Bit 31 is the FULL flag and bits 30:0 are the payload, so a word written with bit 31 clear leaves the slot empty.
- R2: Writing zero to a slot's data word empties the slot. After the write the word reads 0, the slot's EMPTY status bit is 1 and its FULL status bit is 0.
- R3: The status word at 0x304 has bit i = 1 when slot i is empty and bit 8+i = 1 when slot i is full. Bits belonging to slots that are not implemented read 0, and so do bits 31:16.
- R4: The FULL enable at slot offset +0x4 and the EMPTY enable at slot offset +0x8 each keep only bit 0 of the write data. Their other bits read 0.
- R5: The mask of line n at 0x100 + 4·n uses the status layout. Bits for slots that are not implemented, and bits 31:16, read 0.
- R6: Line n is high in the cycle after a status bit, the same bit of mask n and the slot's enable for that condition are all set. It is low one cycle after no such bit remains.
- R7: The lines are level outputs. An enabled and unmasked EMPTY or FULL condition keeps its line high for as long as the condition lasts.
- R8: The dimensioning word at 0x380 reads {12'b0, lines[3:0], doorbells[3:0], arbitrated semaphores[3:0], shared semaphores[3:0], slots[3:0]}. Writes to it have no effect.
- R9: After reset every slot word is 0, so every implemented slot is empty. All enables and masks are 0, and all lines are low.
- R10: Writes to the status word, the dimensioning word or an unmapped address change no state. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, taking effect on the next rising edge |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_o | output | NUM_LINES | Registered, level-sensitive shared interrupt lines |

## Verification
The assertions assume that the register port changes only in response to the clock. They also assume that the lines are fed only by the stored state, so any change to read data at a fixed address must follow a write in the previous cycle. The stimulus meets these assumptions by driving every input shortly after the rising edge and holding it for a whole cycle, by lowering the write strobe between writes, and by reading at addresses that stay the same across idle cycles. The pseudo-random phase mixes slot, enable, mask, status, dimensioning and unmapped addresses. It includes zero writes and payloads with the FULL bit clear, so the lines toggle and also hold at their level.

// File: rtl/smb_pkg.sv
package smb_pkg;
   localparam int unsigned LANE_W      = 8;
   localparam int unsigned FULL_BIT    = 31;
   localparam int unsigned LINE_BASE   = 32'h100;
   localparam int unsigned LINE_STRIDE = 4;
   localparam int unsigned STATUS_OFS  = 32'h304;
   localparam int unsigned DIM_OFS     = 32'h380;
   localparam int unsigned MBOX_BASE   = 32'h400;
   localparam int unsigned MBOX_STRIDE = 32'h10;
   localparam int unsigned OFS_WORD    = 32'h0;
   localparam int unsigned OFS_FEN     = 32'h4;
   localparam int unsigned OFS_EEN     = 32'h8;

   // status layout: full lane above empty lane
   typedef struct packed {
      logic [LANE_W-1:0] full;
      logic [LANE_W-1:0] empty;
   } smb_status_t;

   function automatic int unsigned line_addr(int unsigned n);
      return LINE_BASE + LINE_STRIDE * n;
   endfunction

   function automatic int unsigned slot_addr(int unsigned i, int unsigned ofs);
      return MBOX_BASE + MBOX_STRIDE * i + ofs;
   endfunction
endpackage

// File: rtl/smb_slot.sv
module smb_slot #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_word_i,
   input  logic              wr_fen_i,
   input  logic              wr_een_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] word_o,
   output logic              full_ie_o,
   output logic              empty_ie_o
);
   logic [DATA_W-1:0] word_q;
   logic              fen_q, een_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         fen_q  <= 1'b0;
         een_q  <= 1'b0;
      end else begin
         if (wr_word_i) word_q <= wdata_i;
         if (wr_fen_i)  fen_q  <= wdata_i[0];
         if (wr_een_i)  een_q  <= wdata_i[0];
      end
   end

   assign word_o     = word_q;
   assign full_ie_o  = fen_q;
   assign empty_ie_o = een_q;

   // R2
   zero_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_word_i && wdata_i == '0) |=> (word_o == '0));
   // R1
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_word_i |=> $stable(word_o));
   // R4
   enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_fen_i || wr_een_i) |=> ($stable(full_ie_o) && $stable(empty_ie_o)));
endmodule

// File: rtl/smb_irq_line.sv
module smb_irq_line #(
   parameter int unsigned ST_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_i,
   input  logic [ST_W-1:0] wmask_i,
   input  logic [ST_W-1:0] cond_i,
   output logic [ST_W-1:0] mask_o,
   output logic            irq_o
);
   logic [ST_W-1:0] mask_q;
   logic            irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         if (wr_i) mask_q <= wmask_i;
         irq_q <= |(cond_i & mask_q);
      end
   end

   assign mask_o = mask_q;
   assign irq_o  = irq_q;

   // R6
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |=> !irq_o);
   // R6
   no_cond_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_i == '0) |=> !irq_o);
   // R7
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && $stable(cond_i) && $stable(mask_q)) |=> irq_o);
endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
   import smb_pkg::*;
#(
   parameter int unsigned NUM_MBOX  = 8,
   parameter int unsigned NUM_LINES = 2,
   parameter int unsigned NUM_SS    = 0,
   parameter int unsigned NUM_AS    = 0,
   parameter int unsigned NUM_DB    = 0,
   parameter int unsigned ADDR_W    = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   input  logic                 bus_we,
   output logic [31:0]          bus_rdata,
   output logic [NUM_LINES-1:0] irq_o
);
   localparam int unsigned ST_W = 2 * LANE_W;
   localparam logic [LANE_W-1:0] IMPL = LANE_W'((1 << NUM_MBOX) - 1);
   localparam logic [ST_W-1:0] IMPL_ST = {IMPL, IMPL};
   localparam logic [31:0] DIM_WORD = {12'd0, 4'(NUM_LINES), 4'(NUM_DB),
                                       4'(NUM_AS), 4'(NUM_SS), 4'(NUM_MBOX)};

   // elaboration-time parameter checks
   if (NUM_MBOX < 1 || NUM_MBOX > LANE_W) begin : g_bad_mbox
      $error("smb_ctrl: NUM_MBOX must lie in 1..8");
   end
   if (NUM_LINES < 1 || NUM_LINES > 15) begin : g_bad_lines
      $error("smb_ctrl: NUM_LINES must lie in 1..15");
   end
   if (NUM_SS > 15 || NUM_AS > 15 || NUM_DB > 15) begin : g_bad_caps
      $error("smb_ctrl: capability counts must fit in 4 bits");
   end
   if (ADDR_W < 11 || ADDR_W > 32) begin : g_bad_addr
      $error("smb_ctrl: ADDR_W must lie in 11..32");
   end

   logic [31:0]                    a32;
   logic [NUM_MBOX-1:0][31:0]      words;
   logic [NUM_MBOX-1:0]            fen, een;
   logic [LANE_W-1:0]              full_v, empty_v, fen_v, een_v;
   smb_status_t                    raw, cond;
   logic [NUM_LINES-1:0][ST_W-1:0] masks;

   assign a32 = 32'(bus_addr);

   for (genvar i = 0; i < LANE_W; i++) begin : g_slot
      if (i < NUM_MBOX) begin : g_impl
         smb_slot #(.DATA_W(32)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_word_i  (bus_we && a32 == slot_addr(i, OFS_WORD)),
            .wr_fen_i   (bus_we && a32 == slot_addr(i, OFS_FEN)),
            .wr_een_i   (bus_we && a32 == slot_addr(i, OFS_EEN)),
            .wdata_i    (bus_wdata),
            .word_o     (words[i]),
            .full_ie_o  (fen[i]),
            .empty_ie_o (een[i])
         );
         assign full_v[i]  = words[i][FULL_BIT];
         assign empty_v[i] = ~words[i][FULL_BIT];
         assign fen_v[i]   = fen[i];
         assign een_v[i]   = een[i];
      end else begin : g_absent
         assign full_v[i]  = 1'b0;
         assign empty_v[i] = 1'b0;
         assign fen_v[i]   = 1'b0;
         assign een_v[i]   = 1'b0;
      end
   end

   assign raw.full   = full_v;
   assign raw.empty  = empty_v;
   assign cond.full  = full_v & fen_v;
   assign cond.empty = empty_v & een_v;

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      smb_irq_line #(.ST_W(ST_W)) u_line (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_i    (bus_we && a32 == line_addr(n)),
         .wmask_i (bus_wdata[ST_W-1:0] & IMPL_ST),
         .cond_i  (cond),
         .mask_o  (masks[n]),
         .irq_o   (irq_o[n])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (a32 == STATUS_OFS) bus_rdata = {16'd0, raw};
      if (a32 == DIM_OFS)    bus_rdata = DIM_WORD;
      for (int n = 0; n < NUM_LINES; n++) begin
         if (a32 == line_addr(n)) bus_rdata = {16'd0, masks[n]};
      end
      for (int i = 0; i < NUM_MBOX; i++) begin
         if (a32 == slot_addr(i, OFS_WORD)) bus_rdata = words[i];
         if (a32 == slot_addr(i, OFS_FEN))  bus_rdata = {31'd0, fen[i]};
         if (a32 == slot_addr(i, OFS_EEN))  bus_rdata = {31'd0, een[i]};
      end
   end

   // R10
   read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> ($stable(bus_addr) -> $stable(bus_rdata)));
endmodule

// File: tb/tb_smb_ctrl.sv
`timescale 1ns/1ps
module tb_smb_ctrl;
   localparam int NM = 6;
   localparam int NL = 2;
   localparam int SS = 2;
   localparam int AS = 1;
   localparam int DB = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic        we = 1'b0;
   wire  [31:0] rdata;
   wire  [NL-1:0] irq;

   always #2.5 clk = ~clk;

   smb_ctrl #(.NUM_MBOX(NM), .NUM_LINES(NL), .NUM_SS(SS), .NUM_AS(AS),
              .NUM_DB(DB), .ADDR_W(12)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
      .bus_we(we), .bus_rdata(rdata), .irq_o(irq));

   // behavioural reference state
   int unsigned mb [8];
   int unsigned mf [8];
   int unsigned me [8];
   int unsigned mm [4];
   logic [3:0]  mirq = '0;
   int          nvec = 0;
   int          nerr = 0;
   int          cyc  = 0;
   string       cur_req = "R9";

   function automatic int unsigned m_status();
      int unsigned s = 0;
      for (int i = 0; i < NM; i++)
         if (mb[i][31]) s |= (1 << (8 + i)); else s |= (1 << i);
      return s;
   endfunction

   function automatic int unsigned m_enables();
      int unsigned s = 0;
      for (int i = 0; i < NM; i++) begin
         if (me[i] != 0) s |= (1 << i);
         if (mf[i] != 0) s |= (1 << (8 + i));
      end
      return s;
   endfunction

   function automatic int unsigned m_read(int unsigned a);
      if (a == 32'h304) return m_status();
      if (a == 32'h380) return (NL << 16) | (DB << 12) | (AS << 8) | (SS << 4) | NM;
      if (a >= 32'h100 && a < 32'h100 + 4 * NL && a % 4 == 0) return mm[(a - 32'h100) / 4];
      if (a >= 32'h400 && a < 32'h400 + 16 * NM) begin
         case ((a - 32'h400) % 16)
            0: return mb[(a - 32'h400) / 16];
            4: return mf[(a - 32'h400) / 16];
            8: return me[(a - 32'h400) / 16];
            default: return 0;
         endcase
      end
      return 0;
   endfunction

   function automatic void m_reset();
      for (int i = 0; i < 8; i++) begin mb[i] = 0; mf[i] = 0; me[i] = 0; end
      for (int n = 0; n < 4; n++) mm[n] = 0;
   endfunction

   function automatic void m_write(int unsigned a, int unsigned d);
      int unsigned impl = (1 << NM) - 1;
      if (a >= 32'h100 && a < 32'h100 + 4 * NL && a % 4 == 0)
         mm[(a - 32'h100) / 4] = d & ((impl << 8) | impl);
      if (a >= 32'h400 && a < 32'h400 + 16 * NM) begin
         case ((a - 32'h400) % 16)
            0: mb[(a - 32'h400) / 16] = d;
            4: mf[(a - 32'h400) / 16] = d & 1;
            8: me[(a - 32'h400) / 16] = d & 1;
            default: ;
         endcase
      end
   endfunction

   initial m_reset();

   always @(posedge clk) begin
      if (!rst_n) begin
         m_reset();
         mirq = '0;
      end else begin
         for (int n = 0; n < NL; n++)
            mirq[n] = ((m_status() & mm[n] & m_enables()) != 0);
         if (we) m_write(32'(addr), wdata);
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         nvec += 2;
         if (rdata !== m_read(32'(addr))) begin
            nerr++;
            $display("FAIL %s rdata addr=%03h act=%08h exp=%08h",
                     cur_req, addr, rdata, m_read(32'(addr)));
         end
         if (irq !== mirq[NL-1:0]) begin
            nerr++;
            $display("FAIL %s irq (R6) act=%b exp=%b", cur_req, irq, mirq[NL-1:0]);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         nerr++;
         $display("FAIL watchdog act=%0d cycles exp=completion", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

   task automatic wr(input int unsigned a, input int unsigned d);
      addr = 12'(a); wdata = d; we = 1'b1;
      @(posedge clk); #1;
      we = 1'b0;
   endtask

   task automatic rd(input int unsigned a);
      addr = 12'(a); we = 1'b0;
      @(posedge clk); #1;
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   initial begin
      logic [31:0] lf;
      int unsigned a, d, sel, idx;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      idle(1);

      cur_req = "R9";
      for (int i = 0; i < NM; i++) begin
         rd(32'h400 + 16 * i); rd(32'h404 + 16 * i); rd(32'h408 + 16 * i);
      end
      rd(32'h100); rd(32'h104); rd(32'h304);

      cur_req = "R8";
      rd(32'h380); wr(32'h380, 32'hFFFF_FFFF); rd(32'h380);

      cur_req = "R10";
      wr(32'h304, 32'hFFFF_FFFF); rd(32'h304);
      wr(32'h200, 32'hDEAD_BEEF); rd(32'h200);
      wr(32'h40C, 32'h1234_5678); rd(32'h40C); rd(32'h400);
      wr(32'h400 + 16 * 7, 32'h8000_0001); rd(32'h304);

      cur_req = "R5";
      wr(32'h100, 32'hFFFF_FFFF); rd(32'h100);
      wr(32'h104, 32'h0000_0100); rd(32'h104);
      wr(32'h100, 32'h0); rd(32'h100);

      cur_req = "R4";
      wr(32'h404, 32'hFFFF_FFFE); rd(32'h404);
      wr(32'h404, 32'hFFFF_FFFF); rd(32'h404);
      wr(32'h408, 32'h0000_0003); rd(32'h408);

      cur_req = "R1";
      wr(32'h420, 32'h8000_1234); rd(32'h420);
      wr(32'h450, 32'h7FFF_FFFF); rd(32'h450);

      cur_req = "R3";
      rd(32'h304);

      cur_req = "R6";
      wr(32'h100, 32'h0000_0200);
      wr(32'h414, 32'h1);
      wr(32'h410, 32'h8000_0001);
      idle(3); rd(32'h304);
      wr(32'h438, 32'h1);
      wr(32'h104, 32'h0000_0008);
      idle(2);

      cur_req = "R7";
      idle(10); rd(32'h304); idle(4);

      cur_req = "R2";
      wr(32'h410, 32'h0); rd(32'h410); rd(32'h304); idle(2);
      wr(32'h430, 32'hC000_0000); idle(2);
      wr(32'h430, 32'h0); rd(32'h430); idle(2);

      cur_req = "R6";
      wr(32'h438, 32'h0); idle(3);
      lf = 32'hACE1_2468;
      for (int k = 0; k < 400; k++) begin
         lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
         sel = lf % 10;
         idx = (lf >> 8) % NM;
         d   = (lf[20]) ? 32'(lf) : ((lf[21]) ? 0 : 32'h8000_0000 | (lf >> 12));
         case (sel)
            0, 1, 2: a = 32'h400 + 16 * idx;
            3:       a = 32'h404 + 16 * idx;
            4:       a = 32'h408 + 16 * idx;
            5:       a = 32'h100 + 4 * ((lf >> 4) % NL);
            6:       a = 32'h304;
            7:       a = 32'h380;
            default: a = 32'h200 + (lf % 64);
         endcase
         if (lf[24]) wr(a, d); else rd(a);
         if (lf[25]) idle(1);
      end

      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule